// File: doc/BRIEF.md
# Input Frame Auto-Tune Statistics Engine

This block watches a sampled RGB pixel stream together with its pixel clock, horizontal sync and vertical sync. For each frame it finds the image's bounding box by testing every sampled pixel against a programmable reference black colour. From that box it reports the back porch, active size and total size in both directions. In parallel, one accumulator per colour channel gathers a statistic chosen by a mode field. The statistic is a phase-quality sum of neighbour differences, a histogram threshold count, a minimum or maximum value, or a single-pixel grab at a programmed position.

Firmware arms a measurement with a start pulse and then polls a busy flag. In single mode the engine measures one complete frame, latches the results and stops. In burst mode it refreshes the results at every frame boundary. With interlaced sources, grabbed pixels from the first field and the second field go to separate result banks.

Top module: `autotune_stats`

## Requirements
- R1: A sampled pixel is non-black when at least one channel is strictly greater than that channel's reference value (`cfg_ref_r/g/b`). A pixel equal to the reference counts as black.
- R2: A line begins at the falling edge of `hsync` while `vsync` is low. The first such line after `vsync` falls is line 0. At frame end, `geo_vtot` is the number of lines, `geo_vbp` is the first line holding a non-black pixel, and `geo_vact` is last minus first plus one (0 when the frame has no non-black pixel).
- R3: Inside a line, pixel 0 is the first clock with `hsync` low. `geo_hbp` is the smallest column holding a non-black pixel in the frame and `geo_hact` is the largest minus the smallest plus one. `geo_htot` is the number of low-`hsync` clocks in the last line.
- R4: With `cfg_mode`=0, each channel result is the sum over the frame of |p[x] − p[x−1]| for pixels in the same line, with x ≥ 1.
- R5: With `cfg_mode`=1, each channel result counts the pixels with value ≥ `cfg_thr_*` when `cfg_hist_above`=1, or with value < `cfg_thr_*` when it is 0.
- R6: With `cfg_mode`=2, each channel result is the minimum pixel value of the frame when `cfg_max_sel`=0, or the maximum when it is 1, zero-extended.
- R7: With `cfg_mode`=3 and `cfg_interlace`=0, `res_r` holds {6'b0, B, G, R} of the pixel at column `cfg_grab_x`, line `cfg_grab_y`, and `res_g` and `res_b` are 0.
- R8: With `cfg_mode`=3 and `cfg_interlace`=1, the grabbed pixel goes to `res_r` when `field_id` was 0 at the fall of `vsync`, or to `res_g` when it was 1. The other bank keeps its value and `res_b` is 0.
- R9: The results update only on the clock where `vsync` rises while a measurement is running. The mode in force is the one sampled at the previous `vsync` rise.
- R10: `cfg_start` makes `busy` 1 on the next clock. `busy` returns to 0 when the first complete frame after the start is latched. In single mode (`cfg_burst`=0) no further frame changes the results.
- R11: With `cfg_burst`=1, every later frame is latched in turn, so the results follow the latest frame.
- R12: After reset, `busy` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| field_id | input | 1 | Field identifier, sampled at `vsync` fall |
| pix_r | input | 8 | Red sample |
| pix_g | input | 8 | Green sample |
| pix_b | input | 8 | Blue sample |
| cfg_ref_r | input | 8 | Red reference black |
| cfg_ref_g | input | 8 | Green reference black |
| cfg_ref_b | input | 8 | Blue reference black |
| cfg_mode | input | 2 | 0 difference, 1 histogram, 2 min/max, 3 grab |
| cfg_thr_r | input | 8 | Red histogram threshold |
| cfg_thr_g | input | 8 | Green histogram threshold |
| cfg_thr_b | input | 8 | Blue histogram threshold |
| cfg_hist_above | input | 1 | 1 counts at or above the threshold, 0 counts below it |
| cfg_max_sel | input | 1 | 1 reports maximum, 0 reports minimum |
| cfg_grab_x | input | 11 | Grab column |
| cfg_grab_y | input | 11 | Grab line |
| cfg_interlace | input | 1 | Field-banked grab |
| cfg_burst | input | 1 | Continuous measurement |
| cfg_start | input | 1 | One-clock start pulse |
| busy | output | 1 | 1 while results are not ready |
| geo_vbp | output | 11 | Vertical back porch in lines |
| geo_vact | output | 11 | Active lines |
| geo_vtot | output | 11 | Total lines |
| geo_hbp | output | 11 | Horizontal back porch in pixels |
| geo_hact | output | 11 | Active pixels |
| geo_htot | output | 11 | Pixels per line |
| res_r | output | 30 | Red statistic or first-field grab bank |
| res_g | output | 30 | Green statistic or second-field grab bank |
| res_b | output | 30 | Blue statistic |

## Verification
Frames are built from a seeded pattern. A black background reaches exactly the reference value, and inside a shifting box one channel per pixel is raised above it. This separates the strict comparison and the any-channel rule from off-by-one errors at the box edges. Each statistic mode runs on its own seed: histogram in both directions, min and max, and grab at an inner point and at both corners. Each expected value comes from sweeping the pattern arithmetically. Single and burst sequences then use different seeds in consecutive frames. A stale, early or missed latch, or a grab written to the wrong field bank, therefore gives a different number.

// File: rtl/autotune_pkg.sv
package autotune_pkg;
  typedef enum logic [1:0] {
    MODE_DIFF   = 2'd0,
    MODE_HIST   = 2'd1,
    MODE_MINMAX = 2'd2,
    MODE_GRAB   = 2'd3
  } stat_mode_e;

  typedef enum logic [1:0] {
    RUN_IDLE = 2'd0,
    RUN_WAIT = 2'd1,
    RUN_MEAS = 2'd2
  } run_state_e;
endpackage

// File: rtl/at_sync_track.sv
module at_sync_track #(
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync,
  input  logic             vsync,
  output logic             line_start,
  output logic             vs_rise,
  output logic             vs_fall,
  output logic             pix_ok,
  output logic [POS_W-1:0] cur_x,
  output logic [POS_W-1:0] cur_y,
  output logic [POS_W-1:0] line_len,
  output logic [POS_W-1:0] line_total
);
  function automatic logic [POS_W-1:0] sat_inc(input logic [POS_W-1:0] v);
    return (v == '1) ? v : v + POS_W'(1);
  endfunction

  logic             hs_q, vs_q, y_valid;
  logic [POS_W-1:0] x_reg, y_reg, len_reg;
  logic             hs_rise;

  assign hs_rise    = hsync & ~hs_q;
  assign line_start = hs_q & ~hsync & ~vsync;
  assign vs_rise    = vsync & ~vs_q;
  assign vs_fall    = vs_q & ~vsync;
  assign cur_x      = line_start ? '0 : x_reg;
  assign cur_y      = line_start ? (y_valid ? sat_inc(y_reg) : '0) : y_reg;
  assign pix_ok     = ~hsync & ~vsync & (y_valid | line_start);
  assign line_len   = len_reg;
  assign line_total = y_valid ? sat_inc(y_reg) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      y_valid <= 1'b0;
      x_reg   <= '0;
      y_reg   <= '0;
      len_reg <= '0;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
      if (vs_fall) begin
        y_valid <= 1'b0;
        y_reg   <= '0;
      end else if (line_start) begin
        y_valid <= 1'b1;
        y_reg   <= cur_y;
      end
      if (pix_ok) x_reg <= sat_inc(cur_x);
      if (hs_rise) len_reg <= x_reg;
    end
  end
endmodule

// File: rtl/at_geom.sv
module at_geom #(
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hit,
  input  logic [POS_W-1:0] px_x,
  input  logic [POS_W-1:0] px_y,
  output logic             any,
  output logic [POS_W-1:0] min_x,
  output logic [POS_W-1:0] max_x,
  output logic [POS_W-1:0] min_y,
  output logic [POS_W-1:0] max_y
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any   <= 1'b0;
      min_x <= '1;
      min_y <= '1;
      max_x <= '0;
      max_y <= '0;
    end else if (clr) begin
      any   <= 1'b0;
      min_x <= '1;
      min_y <= '1;
      max_x <= '0;
      max_y <= '0;
    end else if (hit) begin
      any <= 1'b1;
      if (px_x < min_x) min_x <= px_x;
      if (px_x > max_x) max_x <= px_x;
      if (px_y < min_y) min_y <= px_y;
      if (px_y > max_y) max_y <= px_y;
    end
  end
endmodule

// File: rtl/at_chan_stat.sv
module at_chan_stat import autotune_pkg::*; #(
  parameter int PIX_W = 8,
  parameter int ACC_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  stat_mode_e       mode,
  input  logic             pix_ok,
  input  logic             first_px,
  input  logic [PIX_W-1:0] pix,
  input  logic [PIX_W-1:0] thr,
  input  logic             hist_above,
  input  logic             max_sel,
  output logic [ACC_W-1:0] acc
);
  function automatic logic [PIX_W-1:0] abs_gap(input logic [PIX_W-1:0] a,
                                               input logic [PIX_W-1:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic logic hist_hit(input logic [PIX_W-1:0] p,
                                    input logic [PIX_W-1:0] t,
                                    input logic above);
    return above ? (p >= t) : (p < t);
  endfunction

  function automatic logic [PIX_W-1:0] mm_pick(input logic [PIX_W-1:0] cur,
                                               input logic [PIX_W-1:0] p,
                                               input logic want_max);
    if (want_max) return (p > cur) ? p : cur;
    return (p < cur) ? p : cur;
  endfunction

  logic [PIX_W-1:0] prev;
  logic             have;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      prev <= '0;
      have <= 1'b0;
    end else if (clr) begin
      acc  <= '0;
      have <= 1'b0;
    end else if (pix_ok) begin
      prev <= pix;
      unique case (mode)
        MODE_DIFF:   if (!first_px) acc <= acc + ACC_W'(abs_gap(pix, prev));
        MODE_HIST:   if (hist_hit(pix, thr, hist_above)) acc <= acc + ACC_W'(1);
        MODE_MINMAX: begin
          acc  <= have ? ACC_W'(mm_pick(acc[PIX_W-1:0], pix, max_sel)) : ACC_W'(pix);
          have <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/autotune_stats.sv
module autotune_stats import autotune_pkg::*; #(
  parameter int PIX_W = 8,
  parameter int POS_W = 11,
  parameter int ACC_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync,
  input  logic             vsync,
  input  logic             field_id,
  input  logic [PIX_W-1:0] pix_r,
  input  logic [PIX_W-1:0] pix_g,
  input  logic [PIX_W-1:0] pix_b,
  input  logic [PIX_W-1:0] cfg_ref_r,
  input  logic [PIX_W-1:0] cfg_ref_g,
  input  logic [PIX_W-1:0] cfg_ref_b,
  input  logic [1:0]       cfg_mode,
  input  logic [PIX_W-1:0] cfg_thr_r,
  input  logic [PIX_W-1:0] cfg_thr_g,
  input  logic [PIX_W-1:0] cfg_thr_b,
  input  logic             cfg_hist_above,
  input  logic             cfg_max_sel,
  input  logic [POS_W-1:0] cfg_grab_x,
  input  logic [POS_W-1:0] cfg_grab_y,
  input  logic             cfg_interlace,
  input  logic             cfg_burst,
  input  logic             cfg_start,
  output logic             busy,
  output logic [POS_W-1:0] geo_vbp,
  output logic [POS_W-1:0] geo_vact,
  output logic [POS_W-1:0] geo_vtot,
  output logic [POS_W-1:0] geo_hbp,
  output logic [POS_W-1:0] geo_hact,
  output logic [POS_W-1:0] geo_htot,
  output logic [ACC_W-1:0] res_r,
  output logic [ACC_W-1:0] res_g,
  output logic [ACC_W-1:0] res_b
);
  localparam int NCH    = 3;
  localparam int GRAB_W = NCH * PIX_W;

  logic             line_start, vs_rise, vs_fall, pix_ok;
  logic [POS_W-1:0] cur_x, cur_y, line_len, line_total;
  logic             any_nb;
  logic [POS_W-1:0] min_x, max_x, min_y, max_y;
  logic             non_black, grab_hit, latch_ev;
  logic [PIX_W-1:0] px  [NCH];
  logic [PIX_W-1:0] ref_c [NCH];
  logic [PIX_W-1:0] thr [NCH];
  logic [ACC_W-1:0] acc [NCH];
  logic [GRAB_W-1:0] grab_q;
  logic              fld_q;
  stat_mode_e        frame_mode;
  run_state_e        st;

  assign px[0] = pix_r;     assign px[1] = pix_g;     assign px[2] = pix_b;
  assign ref_c[0] = cfg_ref_r; assign ref_c[1] = cfg_ref_g; assign ref_c[2] = cfg_ref_b;
  assign thr[0] = cfg_thr_r; assign thr[1] = cfg_thr_g; assign thr[2] = cfg_thr_b;

  always_comb begin
    non_black = 1'b0;
    for (int c = 0; c < NCH; c++) non_black = non_black | (px[c] > ref_c[c]);
  end

  assign grab_hit = pix_ok && (cur_x == cfg_grab_x) && (cur_y == cfg_grab_y);
  assign latch_ev = vs_rise && (st == RUN_MEAS);

  at_sync_track #(.POS_W(POS_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .line_start(line_start), .vs_rise(vs_rise), .vs_fall(vs_fall), .pix_ok(pix_ok),
    .cur_x(cur_x), .cur_y(cur_y), .line_len(line_len), .line_total(line_total)
  );

  at_geom #(.POS_W(POS_W)) u_geom (
    .clk(clk), .rst_n(rst_n), .clr(vs_rise), .hit(pix_ok & non_black),
    .px_x(cur_x), .px_y(cur_y), .any(any_nb),
    .min_x(min_x), .max_x(max_x), .min_y(min_y), .max_y(max_y)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    at_chan_stat #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .clr(vs_rise), .mode(frame_mode),
      .pix_ok(pix_ok), .first_px(line_start), .pix(px[c]), .thr(thr[c]),
      .hist_above(cfg_hist_above), .max_sel(cfg_max_sel), .acc(acc[c])
    );
  end

  // run control and per-frame capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= RUN_IDLE;
      busy       <= 1'b0;
      frame_mode <= MODE_DIFF;
      grab_q     <= '0;
      fld_q      <= 1'b0;
    end else begin
      busy <= cfg_start ? 1'b1 : (latch_ev ? 1'b0 : busy);
      unique case (st)
        RUN_IDLE: if (cfg_start) st <= RUN_WAIT;
        RUN_WAIT: if (vs_rise) st <= RUN_MEAS;
        default:  if (vs_rise && !cfg_burst) st <= cfg_start ? RUN_WAIT : RUN_IDLE;
      endcase
      if (vs_rise) frame_mode <= stat_mode_e'(cfg_mode);
      if (vs_fall) fld_q <= field_id;
      if (vs_rise) grab_q <= '0;
      else if (grab_hit) grab_q <= {pix_b, pix_g, pix_r};
    end
  end

  // result latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      geo_vbp <= '0; geo_vact <= '0; geo_vtot <= '0;
      geo_hbp <= '0; geo_hact <= '0; geo_htot <= '0;
      res_r <= '0; res_g <= '0; res_b <= '0;
    end else if (latch_ev) begin
      geo_vbp  <= any_nb ? min_y : '0;
      geo_vact <= any_nb ? (max_y - min_y + POS_W'(1)) : '0;
      geo_hbp  <= any_nb ? min_x : '0;
      geo_hact <= any_nb ? (max_x - min_x + POS_W'(1)) : '0;
      geo_vtot <= line_total;
      geo_htot <= line_len;
      if (frame_mode == MODE_GRAB) begin
        res_b <= '0;
        if (!cfg_interlace) begin
          res_r <= ACC_W'(grab_q);
          res_g <= '0;
        end else if (fld_q) begin
          res_g <= ACC_W'(grab_q);
        end else begin
          res_r <= ACC_W'(grab_q);
        end
      end else begin
        res_r <= acc[0];
        res_g <= acc[1];
        res_b <= acc[2];
      end
    end
  end
endmodule

// File: rtl/autotune_stats_chk.sv
module autotune_stats_chk #(
  parameter int POS_W = 11,
  parameter int ACC_W = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_start,
  input logic             busy,
  input logic             latch_ev,
  input logic [ACC_W-1:0] res_r,
  input logic [ACC_W-1:0] res_g,
  input logic [ACC_W-1:0] res_b,
  input logic [POS_W-1:0] geo_vbp,
  input logic [POS_W-1:0] geo_vact,
  input logic [POS_W-1:0] geo_vtot
);
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start |=> busy); // R10
  AST_BUSY_DROPS_AT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(latch_ev)); // R10
  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_ev |=> ($stable(res_r) && $stable(res_g) && $stable(res_b))); // R9
  AST_VGEOM_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, geo_vbp} + {1'b0, geo_vact}) <= {1'b0, geo_vtot}); // R2
endmodule

bind autotune_stats autotune_stats_chk #(.POS_W(POS_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .busy(busy), .latch_ev(latch_ev),
  .res_r(res_r), .res_g(res_g), .res_b(res_b),
  .geo_vbp(geo_vbp), .geo_vact(geo_vact), .geo_vtot(geo_vtot)
);

// File: tb/autotune_stats_bench.sv
`timescale 1ns/1ps
module autotune_stats_bench;
  localparam int W = 8;
  localparam int L = 6;
  localparam int REF = 16;

  logic clk = 1'b0, rst_n = 1'b0, hsync = 1'b1, vsync = 1'b0, field_id = 1'b0;
  logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic [7:0] cfg_thr_r = '0, cfg_thr_g = '0, cfg_thr_b = '0;
  logic [1:0] cfg_mode = '0;
  logic cfg_hist_above = 1'b0, cfg_max_sel = 1'b0, cfg_interlace = 1'b0;
  logic cfg_burst = 1'b0, cfg_start = 1'b0;
  logic [10:0] cfg_grab_x = '0, cfg_grab_y = '0;
  logic busy;
  logic [10:0] geo_vbp, geo_vact, geo_vtot, geo_hbp, geo_hact, geo_htot;
  logic [29:0] res_r, res_g, res_b;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  autotune_stats u_autotune_stats (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .field_id(field_id),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .cfg_ref_r(8'(REF)), .cfg_ref_g(8'(REF)), .cfg_ref_b(8'(REF)),
    .cfg_mode(cfg_mode), .cfg_thr_r(cfg_thr_r), .cfg_thr_g(cfg_thr_g), .cfg_thr_b(cfg_thr_b),
    .cfg_hist_above(cfg_hist_above), .cfg_max_sel(cfg_max_sel),
    .cfg_grab_x(cfg_grab_x), .cfg_grab_y(cfg_grab_y), .cfg_interlace(cfg_interlace),
    .cfg_burst(cfg_burst), .cfg_start(cfg_start), .busy(busy),
    .geo_vbp(geo_vbp), .geo_vact(geo_vact), .geo_vtot(geo_vtot),
    .geo_hbp(geo_hbp), .geo_hact(geo_hact), .geo_htot(geo_htot),
    .res_r(res_r), .res_g(res_g), .res_b(res_b)
  );

  // seeded pattern: box of non-black pixels on a background that reaches REF
  function automatic int bx0(int s); return 2 + s % 3; endfunction
  function automatic int bx1(int s); return 5 + s % 2; endfunction
  function automatic int by0(int s); return 1 + s % 2; endfunction
  function automatic int by1(int s); return 3 + s % 2; endfunction
  function automatic int pv(int s, int y, int x, int c);
    if (y >= by0(s) && y <= by1(s) && x >= bx0(s) && x <= bx1(s) && ((x + y + s) % 3 == c))
      return 40 + ((x * 7 + y * 13 + c * 5 + s * 3) % 200);
    return (x + y + c + s) % 17;
  endfunction

  function automatic longint exp_stat(int s, int mode, int c);
    longint r = 0;
    int hit;
    int th;
    th = (c == 0) ? int'(cfg_thr_r) : (c == 1) ? int'(cfg_thr_g) : int'(cfg_thr_b);
    if (mode == 2) r = pv(s, 0, 0, c);
    for (int y = 0; y < L; y++)
      for (int x = 0; x < W; x++) begin
        int p;
        p = pv(s, y, x, c);
        if (mode == 0 && x > 0) r += (p > pv(s, y, x - 1, c)) ? p - pv(s, y, x - 1, c)
                                                               : pv(s, y, x - 1, c) - p;
        if (mode == 1) begin
          hit = cfg_hist_above ? int'(p >= th) : int'(p < th);
          r += hit;
        end
        if (mode == 2) begin
          if (cfg_max_sel && p > r) r = p;
          if (!cfg_max_sel && p < r) r = p;
        end
      end
    return r;
  endfunction

  function automatic longint exp_grab(int s, int gx, int gy);
    return longint'(pv(s, gy, gx, 2)) * 65536 + longint'(pv(s, gy, gx, 1)) * 256
         + longint'(pv(s, gy, gx, 0));
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic vs_pulse(input logic fld);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); vsync = 1'b1; hsync = 1'b1; field_id = fld;
    end
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); vsync = 1'b0;
    end
  endtask

  task automatic lines(input int s);
    for (int y = 0; y < L; y++) begin
      for (int x = 0; x < W; x++) begin
        @(negedge clk);
        hsync = 1'b0;
        pix_r = 8'(pv(s, y, x, 0)); pix_g = 8'(pv(s, y, x, 1)); pix_b = 8'(pv(s, y, x, 2));
      end
      for (int i = 0; i < 2; i++) begin
        @(negedge clk); hsync = 1'b1; pix_r = '0; pix_g = '0; pix_b = '0;
      end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); cfg_start = 1'b1;
    @(negedge clk); cfg_start = 1'b0;
    chk("R10 busy after start", busy, 1);
  endtask

  task automatic chk_geo(input int s);
    chk("R1 R2 vbp", geo_vbp, by0(s));
    chk("R2 vact", geo_vact, by1(s) - by0(s) + 1);
    chk("R2 vtot", geo_vtot, L);
    chk("R1 R3 hbp", geo_hbp, bx0(s));
    chk("R3 hact", geo_hact, bx1(s) - bx0(s) + 1);
    chk("R3 htot", geo_htot, W);
  endtask

  task automatic chk_stats(input string tag, input int s, input int mode);
    chk({tag, " red"}, res_r, exp_stat(s, mode, 0));
    chk({tag, " green"}, res_g, exp_stat(s, mode, 1));
    chk({tag, " blue"}, res_b, exp_stat(s, mode, 2));
  endtask

  // single-shot run of one seed in a given mode
  task automatic single_run(input int s, input int mode);
    cfg_mode = 2'(mode);
    pulse_start();
    vs_pulse(1'b0);
    lines(s);
    vs_pulse(1'b0);
    chk("R10 busy clear after frame", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R12 busy reset", busy, 0);
    chk("R12 res_r reset", res_r, 0);
    chk("R12 res_g reset", res_g, 0);
    chk("R12 res_b reset", res_b, 0);
    chk("R12 geometry reset", geo_vtot + geo_htot + geo_vact + geo_hact, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 difference mode, then R10 single-shot stop
    single_run(1, 0);
    chk_geo(1);
    chk_stats("R4 diff", 1, 0);
    lines(2);
    vs_pulse(1'b0);
    chk_stats("R10 single stop keeps", 1, 0);
    chk("R10 still ready", busy, 0);

    // R5 histogram both directions
    cfg_thr_r = 8'd100; cfg_thr_g = 8'd60; cfg_thr_b = 8'd9;
    cfg_hist_above = 1'b1;
    single_run(3, 1);
    chk_stats("R5 hist above", 3, 1);
    chk_geo(3);
    cfg_hist_above = 1'b0;
    single_run(4, 1);
    chk_stats("R5 hist below", 4, 1);

    // R6 min and max
    cfg_max_sel = 1'b0;
    single_run(5, 2);
    chk_stats("R6 min", 5, 2);
    cfg_max_sel = 1'b1;
    single_run(6, 2);
    chk_stats("R6 max", 6, 2);

    // R7 grab, non-interlaced, inner point and both corners
    cfg_grab_x = 11'd3; cfg_grab_y = 11'd2;
    single_run(7, 3);
    chk("R7 grab inner", res_r, exp_grab(7, 3, 2));
    chk("R7 grab green bank zero", res_g, 0);
    chk("R7 grab blue bank zero", res_b, 0);
    cfg_grab_x = 11'd0; cfg_grab_y = 11'd0;
    single_run(8, 3);
    chk("R7 grab first corner", res_r, exp_grab(8, 0, 0));
    cfg_grab_x = 11'(W - 1); cfg_grab_y = 11'(L - 1);
    single_run(2, 3);
    chk("R7 grab last corner", res_r, exp_grab(2, W - 1, L - 1));
    chk_geo(2);

    // R8 interlaced banks under R11 burst
    cfg_grab_x = 11'd4; cfg_grab_y = 11'd3;
    cfg_interlace = 1'b1; cfg_burst = 1'b1; cfg_mode = 2'd3;
    pulse_start();
    vs_pulse(1'b0);
    lines(9);
    vs_pulse(1'b1);
    chk("R8 first field bank", res_r, exp_grab(9, 4, 3));
    chk("R11 burst ready", busy, 0);
    lines(10);
    vs_pulse(1'b0);
    chk("R8 second field bank", res_g, exp_grab(10, 4, 3));
    chk("R8 first bank kept", res_r, exp_grab(9, 4, 3));

    // R11 burst refresh in difference mode, then stop
    cfg_interlace = 1'b0; cfg_mode = 2'd0;
    lines(11);
    vs_pulse(1'b0);
    lines(12);
    vs_pulse(1'b0);
    chk_stats("R11 burst frame a", 12, 0);
    chk_geo(12);
    lines(13);
    vs_pulse(1'b0);
    chk_stats("R11 burst frame b", 13, 0);
    cfg_burst = 1'b0;
    lines(14);
    vs_pulse(1'b0);
    chk_stats("R11 last burst frame", 14, 0);
    lines(15);
    vs_pulse(1'b0);
    chk_stats("R9 R10 hold after stop", 14, 0);
    chk("R10 idle ready", busy, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule